// File: doc/BRIEF.md
# Register Save/Restore Stack Sequencer

This block owns a file of eight 32-bit general registers, one of which serves as the stack pointer. It moves register contents to and from a word-wide memory stack through a simple synchronous memory port. The stack grows toward lower addresses, and the pointer always addresses the most recently stored word. A caller issues one of four commands: store one register, load one register, store all eight, or load all eight. While the sequence runs, `busy` is high. A one-cycle `done` pulse marks its end.

The store-all sequence writes a fixed image of the register set. The stack pointer's slot in that image holds the pointer value as it was before the first store. The load-all sequence walks the image back in reverse order and steps over that slot without loading it. The pointer therefore ends exactly where it started, and a store-all followed by a load-all leaves the register file unchanged. A side port lets the surrounding logic write any register while the block is idle and read any register at any time.

Top module: `stack_pushall_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are 0. Register 4 (the stack pointer) holds `SP_INIT`, which is 0x200 by default. Every other register holds 0.
- R2: Command code 0 stores one register, selected by `cmd_reg`. The pointer first drops by 4. The register's value, read before the drop, is then written at the new pointer address. Storing register 4 therefore saves the old pointer.
- R3: Command code 1 loads one register. The word at the current pointer address is read and the pointer rises by 4. The word then lands in the register chosen by `cmd_reg`. When that register is 4, the loaded word wins over the increment.
- R4: Command code 2 stores all registers. Take the pointer value S at the command. After the sequence, address S-4 holds R0, S-8 holds R1, S-12 holds R2, S-16 holds R3, S-20 holds S, S-24 holds R5, S-28 holds R6 and S-32 holds R7. The pointer ends at S-32.
- R5: Command code 3 loads all registers. Starting at pointer P, it loads R7 from P, R6 from P+4, R5 from P+8, R3 from P+16, R2 from P+20, R1 from P+24 and R0 from P+28. The word at P+12 is read but not loaded. The pointer ends at P+32.
- R6: Code 2 followed by code 3 restores every register, the pointer included, to the values it held before code 2.
- R7: Exactly one memory access happens per clock. `done` is high for exactly one cycle, with `busy` low. It is seen this many rising edges after the edge that accepts the command: code 0 after 1, code 1 after 2, code 2 after 8, code 3 after 9. `busy` is high from the cycle after acceptance until `done`.
- R8: While `busy` is high, `cmd_valid` is ignored and side-port register writes are ignored.
- R9: When idle, a side-port write (`rf_wr_en`, `rf_wr_idx`, `rf_wr_data`) takes effect at the next rising edge. `rf_rd_data` shows register `rf_rd_idx` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 store one, 1 load one, 2 store all, 3 load all |
| cmd_reg | input | 3 | Register index for codes 0 and 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_wr_en | input | 1 | Side-port register write enable |
| rf_wr_idx | input | 3 | Side-port write index |
| rf_wr_data | input | 32 | Side-port write data |
| rf_rd_idx | input | 3 | Side-port read index |
| rf_rd_data | output | 32 | Side-port read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 32 | Memory read data, one cycle after the address |

## Verification
Suppose the slot counter or the reverse-order mapping goes wrong. Then the image written by a store-all has words in the wrong slots, which a direct look at the memory shows within nine cycles of the command. A round trip also returns permuted registers. If the pointer snapshot is lost or the skipped slot is loaded, register 4 differs after the load-all. A pointer step of the wrong size shows up on the very next single store or load, as a mismatched address. A sequence-length error moves the `done` pulse off its fixed cycle, and the bench samples `done` on every cycle of each command.

// File: rtl/stack_pushall_seq_pkg.sv
package stack_pushall_seq_pkg;
  typedef enum logic [1:0] {
    OP_PUSH1 = 2'd0,
    OP_POP1  = 2'd1,
    OP_PUSHA = 2'd2,
    OP_POPA  = 2'd3
  } seq_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_TAIL = 2'd2
  } seq_st_e;
endpackage

// File: rtl/stack_pushall_seq_regfile.sv
module stack_pushall_seq_regfile #(
  parameter int DW      = 32,
  parameter int NREG    = 8,
  parameter int SP_IDX  = 4,
  parameter logic [DW-1:0] SP_INIT = 32'h0000_0200,
  localparam int IW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_we,
  input  logic [IW-1:0] ext_idx,
  input  logic [DW-1:0] ext_data,
  input  logic          sp_we,
  input  logic [DW-1:0] sp_data,
  input  logic          wb_we,
  input  logic [IW-1:0] wb_idx,
  input  logic [DW-1:0] wb_data,
  input  logic [IW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  output logic [DW-1:0] sp
);
  logic [DW-1:0] regs [NREG];

  // Priority: memory writeback, then pointer step, then side port.
  always_ff @(posedge clk) begin
    for (int g = 0; g < NREG; g++) begin
      if (!rst_n)
        regs[g] <= (g == SP_IDX) ? SP_INIT : '0;
      else if (wb_we && wb_idx == IW'(g))
        regs[g] <= wb_data;
      else if (g == SP_IDX && sp_we)
        regs[g] <= sp_data;
      else if (ext_we && ext_idx == IW'(g))
        regs[g] <= ext_data;
    end
  end

  assign rd_a_data = regs[rd_a_idx];
  assign rd_b_data = regs[rd_b_idx];
  assign sp        = regs[SP_IDX];
endmodule

// File: rtl/stack_pushall_seq_ctrl.sv
module stack_pushall_seq_ctrl
  import stack_pushall_seq_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NREG   = 8,
  parameter int SP_IDX = 4,
  localparam int IW    = $clog2(NREG),
  localparam int BYTES = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [IW-1:0] cmd_reg,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] push_data,
  input  logic [DW-1:0] mem_rdata,
  output logic [IW-1:0] rd_idx,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          sp_we,
  output logic [DW-1:0] sp_data,
  output logic          wb_we,
  output logic [IW-1:0] wb_idx,
  output logic [DW-1:0] wb_data
);
  function automatic logic [DW-1:0] sp_down(input logic [DW-1:0] p);
    return p - DW'(BYTES);
  endfunction

  function automatic logic [DW-1:0] sp_up(input logic [DW-1:0] p);
    return p + DW'(BYTES);
  endfunction

  function automatic logic [IW-1:0] restore_slot(input logic [IW-1:0] c);
    return IW'(NREG - 1) - c;
  endfunction

  seq_st_e       st_q;
  seq_op_e       op_q;
  logic [IW-1:0] reg_q, cnt_q, wbi_q;
  logic [DW-1:0] sp_snap_q;
  logic          wbp_q;

  logic          xfer, is_push, single, last_step, rd_fire;
  logic [IW-1:0] slot;

  assign xfer      = (st_q == ST_XFER);
  assign is_push   = (op_q == OP_PUSH1) || (op_q == OP_PUSHA);
  assign single    = (op_q == OP_PUSH1) || (op_q == OP_POP1);
  assign last_step = single || (cnt_q == IW'(NREG - 1));
  assign slot      = (op_q == OP_PUSHA) ? cnt_q :
                     (op_q == OP_POPA)  ? restore_slot(cnt_q) : reg_q;
  assign rd_fire   = xfer && !is_push;

  assign rd_idx    = slot;
  assign busy      = (st_q != ST_IDLE);
  assign mem_we    = xfer && is_push;
  assign mem_addr  = is_push ? sp_down(sp) : sp;
  assign mem_wdata = (op_q == OP_PUSHA && slot == IW'(SP_IDX)) ? sp_snap_q : push_data;
  assign sp_we     = xfer;
  assign sp_data   = is_push ? sp_down(sp) : sp_up(sp);
  assign wb_we     = wbp_q;
  assign wb_idx    = wbi_q;
  assign wb_data   = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_PUSH1;
      reg_q     <= '0;
      cnt_q     <= '0;
      sp_snap_q <= '0;
      wbp_q     <= 1'b0;
      wbi_q     <= '0;
      done      <= 1'b0;
    end else begin
      done  <= 1'b0;
      wbp_q <= rd_fire && !(op_q == OP_POPA && slot == IW'(SP_IDX));
      wbi_q <= slot;
      unique case (st_q)
        ST_IDLE: if (cmd_valid) begin
          st_q      <= ST_XFER;
          op_q      <= seq_op_e'(cmd_op);
          reg_q     <= cmd_reg;
          cnt_q     <= '0;
          sp_snap_q <= sp;
        end
        ST_XFER: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) begin
            st_q <= is_push ? ST_IDLE : ST_TAIL;
            done <= is_push;
          end
        end
        ST_TAIL: begin
          st_q <= ST_IDLE;
          done <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4: the saved-pointer slot carries the value from before the first store
  a_r4_saved_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && op_q == OP_PUSHA && cnt_q == IW'(SP_IDX))
      |-> mem_wdata == sp + DW'(BYTES * SP_IDX));

  // R3: every read step advances the pointer by one word
  a_r3_pop_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> sp == $past(sp) + DW'(BYTES));

  // R8: the latched command does not change while a sequence runs
  a_r8_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q) && $stable(reg_q));
endmodule

// File: rtl/stack_pushall_seq.sv
module stack_pushall_seq #(
  parameter int DW     = 32,
  parameter int NREG   = 8,
  parameter int SP_IDX = 4,
  parameter logic [DW-1:0] SP_INIT = 32'h0000_0200,
  localparam int IW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [IW-1:0] cmd_reg,
  output logic          busy,
  output logic          done,
  input  logic          rf_wr_en,
  input  logic [IW-1:0] rf_wr_idx,
  input  logic [DW-1:0] rf_wr_data,
  input  logic [IW-1:0] rf_rd_idx,
  output logic [DW-1:0] rf_rd_data,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);
  logic [DW-1:0] sp, push_data, sp_data, wb_data;
  logic [IW-1:0] seq_rd_idx, wb_idx;
  logic          sp_we, wb_we, ext_we;

  assign ext_we = rf_wr_en && !busy;

  stack_pushall_seq_regfile #(.DW(DW), .NREG(NREG), .SP_IDX(SP_IDX), .SP_INIT(SP_INIT)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ext_we(ext_we), .ext_idx(rf_wr_idx), .ext_data(rf_wr_data),
    .sp_we(sp_we), .sp_data(sp_data),
    .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data),
    .rd_a_idx(seq_rd_idx), .rd_a_data(push_data),
    .rd_b_idx(rf_rd_idx), .rd_b_data(rf_rd_data),
    .sp(sp)
  );

  stack_pushall_seq_ctrl #(.DW(DW), .NREG(NREG), .SP_IDX(SP_IDX)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
    .sp(sp), .push_data(push_data), .mem_rdata(mem_rdata),
    .rd_idx(seq_rd_idx), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .sp_we(sp_we), .sp_data(sp_data),
    .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // R2: a store lands at the address the pointer then holds
  a_r2_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(mem_addr));

  // R7: completion is a single-cycle pulse seen while idle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r7_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
endmodule

// File: tb/stack_pushall_seq_test.sv
`timescale 1ns/1ps
module stack_pushall_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_reg;
  logic        busy, done;
  logic        rf_wr_en;
  logic [2:0]  rf_wr_idx, rf_rd_idx;
  logic [31:0] rf_wr_data, rf_rd_data;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  logic [31:0] mem [256];
  logic [31:0] m_r [8];
  logic [31:0] m_mem [256];
  logic [31:0] saved [8];
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  stack_pushall_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
    .busy(busy), .done(done), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
    .rf_wr_data(rf_wr_data), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'h0;
      mem_rdata <= 32'h0;
    end else begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [1:0] op);
    case (op)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 9;
    endcase
  endfunction

  // Independent model of the stack behaviour
  task automatic model_cmd(input logic [1:0] op, input logic [2:0] r);
    logic [31:0] v, s;
    case (op)
      2'd0: begin v = m_r[r]; m_r[4] = m_r[4] - 4; m_mem[m_r[4][9:2]] = v; end
      2'd1: begin v = m_mem[m_r[4][9:2]]; m_r[4] = m_r[4] + 4; m_r[r] = v; end
      2'd2: begin
        s = m_r[4];
        for (int k = 0; k < 8; k++) begin
          v = (k == 4) ? s : m_r[k];
          m_r[4] = m_r[4] - 4;
          m_mem[m_r[4][9:2]] = v;
        end
      end
      default: begin
        for (int k = 7; k >= 0; k--) begin
          v = m_mem[m_r[4][9:2]];
          m_r[4] = m_r[4] + 4;
          if (k != 4) m_r[k] = v;
        end
      end
    endcase
  endtask

  task automatic rd_reg(input logic [2:0] idx, output logic [31:0] v);
    @(negedge clk);
    rf_rd_idx = idx;
    #0.5;
    v = rf_rd_data;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      rd_reg(3'(k), v);
      chk(req, v, m_r[k]);
    end
  endtask

  task automatic ext_wr(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    rf_wr_en = 1'b1; rf_wr_idx = idx; rf_wr_data = val;
    @(negedge clk);
    rf_wr_en = 1'b0;
    m_r[idx] = val;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [2:0] r, input string req);
    int lat;
    lat = lat_of(op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_reg = r;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " busy after accept"}, 32'(busy), 32'd1);
    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      chk({req, " R7 done timing"}, 32'(done), (i == lat) ? 32'd1 : 32'd0);
    end
    model_cmd(op, r);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [1:0] op;
    logic [2:0] r;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_reg = 3'd0;
    rf_wr_en = 1'b0; rf_wr_idx = 3'd0; rf_wr_data = 32'h0; rf_rd_idx = 3'd0;
    for (int i = 0; i < 8; i++) m_r[i] = (i == 4) ? 32'h200 : 32'h0;
    for (int i = 0; i < 256; i++) m_mem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 mem_we", 32'(mem_we), 32'd0);
    check_all("R1 regs");

    // R9 side port write and read
    for (int k = 0; k < 8; k++) if (k != 4) ext_wr(3'(k), 32'h1111_0000 + 32'(k * 17));
    check_all("R9 side port");

    // R2 store the pointer itself: old value lands at new top
    run_cmd(2'd0, 3'd4, "R2 push sp");
    chk("R2 slot holds old sp", mem[9'h1FC >> 2], 32'h200);
    check_all("R2 regs");

    // R3 load into the pointer: loaded word wins
    ext_wr(3'd1, 32'h0000_0300);
    run_cmd(2'd0, 3'd1, "R2 push r1");
    run_cmd(2'd1, 3'd4, "R3 pop sp");
    chk("R3 sp loaded", m_r[4], 32'h300);
    check_all("R3 regs");
    ext_wr(3'd4, 32'h200);

    // R4 store-all image layout
    for (int k = 0; k < 8; k++) begin
      saved[k] = (k == 4) ? 32'h200 : 32'hA0A0_0000 + 32'(k);
      if (k != 4) ext_wr(3'(k), saved[k]);
    end
    run_cmd(2'd2, 3'd0, "R4 push all");
    for (int k = 0; k < 8; k++)
      chk("R4 image slot", mem[(32'h200 - 32'(4 * (k + 1))) >> 2], saved[k]);
    check_all("R4 regs");

    // R5/R6 scribble then restore
    for (int k = 0; k < 8; k++) if (k != 4) ext_wr(3'(k), 32'hDEAD_0000 + 32'(k));
    run_cmd(2'd3, 3'd0, "R5 pop all");
    for (int k = 0; k < 8; k++) begin
      rd_reg(3'(k), v);
      chk("R6 round trip", v, saved[k]);
    end

    // R5 skipped slot: plant a foreign pointer value in the image
    run_cmd(2'd2, 3'd0, "R5 setup push all");
    mem[(32'h200 - 32'd20) >> 2] = 32'h0BAD_0BAD;
    m_mem[(32'h200 - 32'd20) >> 2] = 32'h0BAD_0BAD;
    run_cmd(2'd3, 3'd0, "R5 pop all skip");
    rd_reg(3'd4, v);
    chk("R5 sp not loaded", v, 32'h200);
    check_all("R5 regs");

    // R8 command and side write during busy are ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_reg = 3'd0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_reg = 3'd1;
    rf_wr_en = 1'b1; rf_wr_idx = 3'd2; rf_wr_data = 32'hFFFF_1234;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; rf_wr_en = 1'b0;
    model_cmd(2'd2, 3'd0);
    begin
      int guard = 0;
      while (!done && guard < 50) begin @(negedge clk); guard++; end
    end
    @(negedge clk);
    chk("R8 no extra command", 32'(busy), 32'd0);
    check_all("R8 regs");

    // Random mix
    for (int it = 0; it < 60; it++) begin
      op = 2'($urandom % 4);
      r = 3'($urandom % 8);
      if ($urandom % 3 == 0) ext_wr(3'($urandom % 4), $urandom);
      if (!op[0] && m_r[4] < 32'h80) op[0] = 1'b1;
      if (op[0] && m_r[4] > 32'h380) op[0] = 1'b0;
      run_cmd(op, r, "R7 random");
      check_all(op[0] ? "R3 R5 random" : "R2 R4 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule